// File: doc/BRIEF.md
# Asynchronous Static RAM Port Controller

This block connects a synchronous on-chip request port to an external asynchronous static RAM of 262,144 sixteen-bit words with separate byte lanes. A requester presents an address, write data, a per-lane strobe pair and a direction flag under a valid/ready handshake. The controller then runs one access on the memory pins. It drives the active-low select, read-enable, write-enable and per-lane enables. It also drives the output value and direction control of the shared data bus, which a pad ring outside the block resolves.

Each access holds its control lines for a wait count. That count is derived at elaboration from the memory's access time and the clock period, so one parameter pair covers any speed grade. Reads return a one-cycle response pulse carrying the captured word. Byte lanes that were not requested come back as zero. A write that follows a read gets an extra idle cycle, so the bus never has two drivers. A write with no lanes selected finishes at once and leaves the memory untouched.

Top module: `asram_port`

## Requirements
- R1: After reset, mem_ce_n, mem_oe_n, mem_we_n and both mem_be_n bits are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: The wait count WAITS equals the ceiling of ACCESS_PS divided by CLK_PS, and is at least 1.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 for the whole time mem_ce_n is 0.
- R4: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for WAITS cycles. mem_be_n is the inverse of req_be, where bit 0 is the low lane (data bits 7:0) and bit 1 is the high lane (bits 15:8). rsp_valid rises WAITS edges after the accepting edge.
- R5: rsp_valid is high for exactly one cycle per read. rsp_rdata holds the word at the read address, with each lane whose strobe was 0 returned as 8'h00.
- R6: A write with at least one strobe set holds mem_we_n=0 and mem_ce_n=0 for exactly WAITS cycles. The bus is driven with the write data for that whole time, and only the strobed lanes of the memory change.
- R7: After mem_we_n rises, the bus stays driven for one more cycle, with mem_ce_n=0 and the address unchanged. It is then released. A write occupies the block for WAITS+1 cycles.
- R8: While mem_ce_n stays 0, mem_addr and mem_be_n do not change.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0.
- R10: A write accepted when the previous non-empty access was a read spends one extra cycle with all controls high before mem_we_n falls.
- R11: A write with req_be=2'b00 never pulls mem_we_n low, and req_ready is 1 again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Lane strobes, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | DATA_W | Read data, unrequested lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_be_n | output | DATA_W/8 | Lane enables, active low |
| mem_dq_out | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | 1 when the controller drives the bus |
| mem_dq_in | input | DATA_W | Value read back from the data bus |

## Verification
The bench builds the controller with a 5000 ps clock and a 17000 ps access time, which gives a wait count of four. With that count, the counter passes through more than one intermediate value, so a faulty ceiling, an off-by-one load or a short write pulse changes the response latency and the write-enable run length where the bench measures them. Mixed random reads and writes over a small address pool with both ends of the address range bring in read-after-write, write-after-read turnaround, partial-lane merges and empty-strobe writes.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WR   = 3'd2,
      ST_WREC = 3'd3,
      ST_TURN = 3'd4
   } ctl_st_e;

   // ceil(access / period), never below one cycle
   function automatic int wait_cycles(input int access_ps, input int period_ps);
      int n;
      n = (access_ps + period_ps - 1) / period_ps;
      return (n < 1) ? 1 : n;
   endfunction

endpackage

// File: rtl/asram_wait_ctr.sv
module asram_wait_ctr #(
   parameter int WAITS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic last
);
   localparam int CNT_W = (WAITS < 2) ? 1 : $clog2(WAITS);
   localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(WAITS - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= LOAD_V;
      else if (run && cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign last = (cnt == '0);
endmodule

// File: rtl/asram_lane_mask.sv
module asram_lane_mask #(
   parameter int LANES = 2
) (
   input  logic [LANES*8-1:0] din,
   input  logic [LANES-1:0]   keep,
   output logic [LANES*8-1:0] dout
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dout[g*8 +: 8] = keep[g] ? din[g*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/asram_port.sv
module asram_port #(
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 16,
   parameter int CLK_PS    = 5000,
   parameter int ACCESS_PS = 12000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W/8-1:0]   req_be,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic                  mem_ce_n,
   output logic                  mem_oe_n,
   output logic                  mem_we_n,
   output logic [DATA_W/8-1:0]   mem_be_n,
   output logic [DATA_W-1:0]     mem_dq_out,
   output logic                  mem_dq_oe,
   input  logic [DATA_W-1:0]     mem_dq_in
);
   import asram_pkg::*;

   localparam int LANES = DATA_W / 8;
   localparam int WAITS = wait_cycles(ACCESS_PS, CLK_PS);

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("asram_port: DATA_W must be a positive multiple of 8");
   end
   if (CLK_PS < 1 || ACCESS_PS < 1) begin : g_bad_time
      $error("asram_port: timing parameters must be positive");
   end

   ctl_st_e             st, st_nx;
   logic [ADDR_W-1:0]   a_q;
   logic [DATA_W-1:0]   d_q;
   logic [LANES-1:0]    be_q;
   logic                prev_rd_q;
   logic                rsp_v_q;
   logic [DATA_W-1:0]   rsp_d_q;
   logic [DATA_W-1:0]   masked;
   logic                accept, empty_wr, cnt_load, cnt_last, in_access;

   assign accept   = req_valid && (st == ST_IDLE);
   assign empty_wr = req_write && (req_be == '0);

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (accept) begin
            if (!req_write)     st_nx = ST_RD;
            else if (empty_wr)  st_nx = ST_IDLE;
            else if (prev_rd_q) st_nx = ST_TURN;
            else                st_nx = ST_WR;
         end
         ST_RD:   if (cnt_last) st_nx = ST_IDLE;
         ST_WR:   if (cnt_last) st_nx = ST_WREC;
         ST_WREC: st_nx = ST_IDLE;
         ST_TURN: st_nx = ST_WR;
         default: st_nx = ST_IDLE;
      endcase
   end

   assign cnt_load = (st != ST_RD && st != ST_WR) &&
                     (st_nx == ST_RD || st_nx == ST_WR);

   asram_wait_ctr #(.WAITS(WAITS)) u_wait (
      .clk  (clk),
      .rst_n(rst_n),
      .load (cnt_load),
      .run  (st == ST_RD || st == ST_WR),
      .last (cnt_last)
   );

   asram_lane_mask #(.LANES(LANES)) u_mask (
      .din (mem_dq_in),
      .keep(be_q),
      .dout(masked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         a_q       <= '0;
         d_q       <= '0;
         be_q      <= '0;
         prev_rd_q <= 1'b0;
         rsp_v_q   <= 1'b0;
         rsp_d_q   <= '0;
      end else begin
         st      <= st_nx;
         rsp_v_q <= (st == ST_RD) && cnt_last;
         if (accept && !empty_wr) begin
            a_q  <= req_addr;
            d_q  <= req_wdata;
            be_q <= req_be;
         end
         if (st == ST_RD && cnt_last) begin
            rsp_d_q   <= masked;
            prev_rd_q <= 1'b1;
         end
         if (st == ST_WREC) prev_rd_q <= 1'b0;
      end
   end

   assign in_access  = (st == ST_RD) || (st == ST_WR) || (st == ST_WREC);
   assign req_ready  = (st == ST_IDLE);
   assign rsp_valid  = rsp_v_q;
   assign rsp_rdata  = rsp_d_q;
   assign mem_addr   = a_q;
   assign mem_ce_n   = !in_access;
   assign mem_oe_n   = !(st == ST_RD);
   assign mem_we_n   = !(st == ST_WR);
   assign mem_be_n   = in_access ? ~be_q : '1;
   assign mem_dq_out = d_q;
   assign mem_dq_oe  = (st == ST_WR) || (st == ST_WREC);
endmodule

// File: rtl/asram_port_chk.sv
module asram_port_chk #(
   parameter int ADDR_W    = 18,
   parameter int DATA_W    = 16,
   parameter int CLK_PS    = 5000,
   parameter int ACCESS_PS = 12000
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_ready,
   input logic                rsp_valid,
   input logic [ADDR_W-1:0]   mem_addr,
   input logic                mem_ce_n,
   input logic                mem_oe_n,
   input logic                mem_we_n,
   input logic [DATA_W/8-1:0] mem_be_n,
   input logic                mem_dq_oe
);
   localparam int WAITS = asram_pkg::wait_cycles(ACCESS_PS, CLK_PS);

   int we_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         we_run <= 0;
      else if (!mem_we_n) we_run <= we_run + 1;
      else                we_run <= 0;
   end

   a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_ce_n) |-> (mem_we_n && mem_oe_n && (&mem_be_n)));
   a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n) |-> !req_ready);
   a_r4_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n) |-> (mem_we_n && !mem_ce_n));
   a_r5_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   a_r6_we_run_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run == WAITS));
   a_r6_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n) |-> (mem_dq_oe && !mem_ce_n));
   a_r7_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n));
   a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));
   a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_oe_n) |-> !mem_dq_oe);
   a_r10_ce_high_before_we: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(mem_ce_n));
endmodule

bind asram_port asram_port_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PS(CLK_PS), .ACCESS_PS(ACCESS_PS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
   .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_asram_port.sv
module tb_asram_port;
   localparam int AW = 18;
   localparam int DW = 16;
   localparam int CLK_PS = 5000;
   localparam int ACC_PS = 17000;
   localparam int W = (ACC_PS + CLK_PS - 1) / CLK_PS;   // R2: expected 4

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0] req_be = '0;
   logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;
   logic [1:0] mem_be_n;

   always #2500 clk = ~clk;   // 200 MHz

   asram_port #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .ACCESS_PS(ACC_PS)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

   // memory model and bench reference
   logic [DW-1:0] sram [bit [AW-1:0]];
   logic [DW-1:0] ref_mem [bit [AW-1:0]];
   int checks = 0, failures = 0, mon_err = 0, we_falls = 0;
   logic we_prev = 1'b1;
   bit finished = 0;

   function automatic logic [DW-1:0] rd_word(input logic [AW-1:0] a);
      return sram.exists(a) ? sram[a] : '0;
   endfunction

   always_comb begin
      logic [DW-1:0] w;
      w = rd_word(mem_addr);
      mem_dq_in = 16'hA5A5;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
         if (!mem_be_n[0]) mem_dq_in[7:0]  = w[7:0];
         if (!mem_be_n[1]) mem_dq_in[15:8] = w[15:8];
      end
   end

   always @(posedge clk) begin
      if (!mem_ce_n && !mem_we_n) begin
         logic [DW-1:0] w;
         w = rd_word(mem_addr);
         if (!mem_be_n[0]) w[7:0]  = mem_dq_out[7:0];
         if (!mem_be_n[1]) w[15:8] = mem_dq_out[15:8];
         sram[mem_addr] = w;
      end
      if (we_prev && !mem_we_n) we_falls++;
      we_prev <= mem_we_n;
   end

   // R9 / R6 bus monitor, sampled away from the edge
   always @(negedge clk) if (rst_n) begin
      if (mem_dq_oe && !mem_oe_n) mon_err++;
      if (!mem_we_n && !mem_dq_oe) mon_err++;
   end

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic [1:0] be);
      logic [DW-1:0] w;
      w = ref_mem.exists(a) ? ref_mem[a] : '0;
      return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
   endfunction

   function automatic void ref_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                                     input logic [1:0] be);
      logic [DW-1:0] w;
      w = ref_mem.exists(a) ? ref_mem[a] : '0;
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      ref_mem[a] = w;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   bit prev_rd = 0;

   task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] be);
      int n, falls0, exp_n;
      @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      while (!req_ready) @(negedge clk);
      falls0 = we_falls;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      n = 1;
      if (!wr) begin
         while (!rsp_valid && n < 50) begin @(negedge clk); n++; end
         check(n == W + 1, "R4 read latency", n, W + 1);
         check(rsp_rdata == exp_read(a, be), "R5 read data", rsp_rdata, exp_read(a, be));
         @(negedge clk);
         check(!rsp_valid, "R5 single pulse", rsp_valid, 0);
         prev_rd = 1;
      end else begin
         while (!req_ready && n < 50) begin @(negedge clk); n++; end
         if (be == 2'b00) begin
            check(n == 1, "R11 empty write ready", n, 1);
            check(we_falls == falls0, "R11 no write strobe", we_falls - falls0, 0);
         end else begin
            exp_n = prev_rd ? W + 3 : W + 2;
            check(n == exp_n, prev_rd ? "R10 turnaround length" : "R7 write length", n, exp_n);
            check(we_falls == falls0 + 1, "R6 one write strobe", we_falls - falls0, 1);
            ref_write(a, d, be);
            prev_rd = 0;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] pool [8];
      void'($urandom(32'd1041));
      pool[0] = '0; pool[1] = 18'h3FFFF;
      for (int i = 2; i < 8; i++) pool[i] = AW'($urandom);
      #1;
      check(mem_ce_n && mem_oe_n && mem_we_n && mem_be_n == 2'b11 && !mem_dq_oe,
            "R1 reset pins", {mem_ce_n, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe}, 6'b111110);
      check(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      // directed: lane writes at both address ends, then masked reads
      do_op(1, 18'h3FFFF, 16'hBEEF, 2'b11);
      do_op(1, 18'h3FFFF, 16'h1234, 2'b01);          // R6 low lane only
      do_op(0, 18'h3FFFF, 16'h0, 2'b11);             // expect BE34
      do_op(0, 18'h3FFFF, 16'h0, 2'b10);             // R5 low lane zero
      do_op(1, 18'h00000, 16'h5A5A, 2'b10);          // R10 write after read
      do_op(1, 18'h00000, 16'hFFFF, 2'b00);          // R11 empty write
      do_op(0, 18'h00000, 16'h0, 2'b01);
      do_op(0, 18'h00000, 16'h0, 2'b11);

      for (int k = 0; k < 300; k++) begin
         bit wr;
         wr = $urandom_range(0, 1) == 1;
         do_op(wr, pool[$urandom_range(0, 7)], DW'($urandom), 2'($urandom_range(0, 3)));
      end

      check(mon_err == 0, "R9 bus ownership", mon_err, 0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule